// File: doc/BRIEF.md
# Trace Instruction-Count and History Tracker

This block sits next to a processor's retirement port and keeps the two running quantities a branch-trace encoder needs between messages: a count of the halfwords retired since the last message, and a taken/not-taken history word for direct conditional branches. One retired instruction is offered per handshake. Each carries its size, its branch kind, a taken flag, and the current trace mode, which is either branch mode or history mode.

When an instruction ends a code block, the block raises a message request that carries the present count and history. It raises the same kind of request when either quantity runs out of room. Requests go to a downstream message formatter over a valid/ready handshake. While any request is still waiting, the retirement port is held off and no state changes. A single instruction can produce up to two requests, and they are presented one after another in a fixed order.

Top module: `trace_block_tracker`

## Requirements
- R1: After reset, `icnt_o` is 0, `hist_o` is 1 (only the marker bit is set), `msg_valid_o` is 0 and `ret_ready_o` is 1.
- R2: A retired instruction that does not end a block and does not overflow adds 1 to `icnt_o` when `ret_size_i`=0 (16-bit) and 2 when `ret_size_i`=1 (32-bit). These instructions are kind 0 (sequential), kind 2 (direct jump), and kind 1 (direct conditional) when it is not taken in branch mode. They raise no request.
- R3: In history mode (`hist_mode_i`=1), a kind 1 instruction raises no request by itself. It shifts its taken flag into bit 0 of `hist_o`, moving the older bits up, and it advances the count as in R2.
- R4: In branch mode (`hist_mode_i`=0), a taken kind 1 instruction raises a request of type 1. The request's count is the running count including this instruction, and its history is the current `hist_o`. Afterwards the count is 0 and the history is 1.
- R5: A kind 3 instruction (indirect branch or jump), in either mode, raises a request of type 0. Its count and history are formed as in R4, and the count and history are cleared in the same way afterwards.
- R6: When the running count plus the instruction's size would exceed 2^ICNT_W-1, a request of type 2 is raised. It carries the count before this instruction, with a history field of 0. Counting then restarts from the instruction's size. If the instruction also ends a block, its block request carries just that size.
- R7: When a history shift moves the marker into bit HIST_W-1, a request of type 3 is raised. It carries that full history word, with a count field of 0, and the history returns to 1.
- R8: When one instruction causes two requests, type 2 is presented first, followed by type 3 or by the block request.
- R9: While `msg_valid_o` is 1 and `msg_ready_i` is 0, the request fields stay unchanged. While any request is pending, `ret_ready_o` is 0 and an offered instruction changes neither `icnt_o` nor `hist_o`.
- R10: In branch mode, `hist_o` changes only when a block ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hist_mode_i | input | 1 | 1 = history mode, 0 = branch mode |
| ret_valid_i | input | 1 | A retired instruction is offered |
| ret_ready_o | output | 1 | The offered instruction is taken this cycle |
| ret_size_i | input | 1 | 0 = one halfword, 1 = two halfwords |
| ret_kind_i | input | 2 | 0 sequential, 1 direct conditional, 2 direct jump, 3 indirect |
| ret_taken_i | input | 1 | Outcome of a conditional branch |
| msg_valid_o | output | 1 | A request is presented |
| msg_ready_i | input | 1 | The formatter accepts the request |
| msg_type_o | output | 2 | 0 indirect, 1 direct taken, 2 count full, 3 history full |
| msg_icnt_o | output | ICNT_W | Count carried by the request |
| msg_hist_o | output | HIST_W | History carried by the request |
| icnt_o | output | ICNT_W | Running halfword count |
| hist_o | output | HIST_W | Running history word with its marker |

## Verification
A wrong count or history shows up at `icnt_o` and `hist_o` in the cycle after the instruction that caused it. It shows up again later in the payload of the next request. A lost marker or a wrong full-detection point appears as a request type 3 that is missing, early or late. An error in overflow handling appears as a type 2 request with the wrong value, or as a wrong restart count one cycle after the instruction. Ordering and stall faults appear in the sequence of requests, each presented one cycle after the previous one is accepted, and as state that moves while `ret_ready_o` is low.

// File: rtl/trace_blk_pkg.sv
package trace_blk_pkg;
  typedef enum logic [1:0] {
    MSG_IND       = 2'd0,
    MSG_DIR       = 2'd1,
    MSG_FULL_CNT  = 2'd2,
    MSG_FULL_HIST = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    RK_SEQ   = 2'd0,
    RK_DCOND = 2'd1,
    RK_DJUMP = 2'd2,
    RK_INDIR = 2'd3
  } ret_kind_e;

  // slot order is presentation priority
  localparam int NSLOT     = 3;
  localparam int SLOT_CNT  = 0;
  localparam int SLOT_HIST = 1;
  localparam int SLOT_BR   = 2;
endpackage

// File: rtl/tbt_icnt_unit.sv
module tbt_icnt_unit #(
  parameter int ICNT_W = 8
) (
  input  logic [ICNT_W-1:0] cnt_q_i,
  input  logic              size_i,
  input  logic              ends_i,
  output logic [ICNT_W-1:0] cnt_d_o,
  output logic              ovf_o,
  output logic [ICNT_W-1:0] blk_cnt_o
);
  logic [ICNT_W:0]   sum;
  logic [ICNT_W-1:0] incr;
  logic [ICNT_W-1:0] base;

  always_comb begin
    incr = size_i ? ICNT_W'(2) : ICNT_W'(1);
    sum  = {1'b0, cnt_q_i} + {1'b0, incr};
    // carry out means the count no longer fits
    ovf_o = sum[ICNT_W];
    base  = ovf_o ? incr : sum[ICNT_W-1:0];
    blk_cnt_o = base;
    cnt_d_o   = ends_i ? '0 : base;
  end
endmodule

// File: rtl/tbt_hist_unit.sv
module tbt_hist_unit #(
  parameter int HIST_W = 8
) (
  input  logic [HIST_W-1:0] hist_q_i,
  input  logic              shift_i,
  input  logic              taken_i,
  input  logic              clear_i,
  output logic [HIST_W-1:0] hist_d_o,
  output logic [HIST_W-1:0] shifted_o,
  output logic              full_o
);
  localparam logic [HIST_W-1:0] MARKER = HIST_W'(1);

  always_comb begin
    shifted_o = {hist_q_i[HIST_W-2:0], taken_i};
    full_o    = shift_i & shifted_o[HIST_W-1];
    if (clear_i || full_o) hist_d_o = MARKER;
    else if (shift_i)      hist_d_o = shifted_o;
    else                   hist_d_o = hist_q_i;
  end
endmodule

// File: rtl/tbt_msg_slots.sv
module tbt_msg_slots
  import trace_blk_pkg::*;
#(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [NSLOT-1:0]              ld_v_i,
  input  logic [NSLOT-1:0][1:0]         ld_type_i,
  input  logic [NSLOT-1:0][ICNT_W-1:0]  ld_icnt_i,
  input  logic [NSLOT-1:0][HIST_W-1:0]  ld_hist_i,
  input  logic                          msg_ready_i,
  output logic                          msg_valid_o,
  output logic [1:0]                    msg_type_o,
  output logic [ICNT_W-1:0]             msg_icnt_o,
  output logic [HIST_W-1:0]             msg_hist_o,
  output logic                          busy_o
);
  localparam int SEL_W = $clog2(NSLOT);

  logic [NSLOT-1:0]             v_q;
  logic [NSLOT-1:0][1:0]        type_q;
  logic [NSLOT-1:0][ICNT_W-1:0] icnt_q;
  logic [NSLOT-1:0][HIST_W-1:0] hist_q;
  logic [SEL_W-1:0]             sel;
  logic                         pop;

  always_comb begin
    sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (v_q[i]) sel = SEL_W'(i);
    end
  end

  assign busy_o      = |v_q;
  assign msg_valid_o = busy_o;
  assign msg_type_o  = type_q[sel];
  assign msg_icnt_o  = icnt_q[sel];
  assign msg_hist_o  = hist_q[sel];
  assign pop         = busy_o & msg_ready_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g]    <= 1'b0;
        type_q[g] <= '0;
        icnt_q[g] <= '0;
        hist_q[g] <= '0;
      end else if (load_i) begin
        v_q[g]    <= ld_v_i[g];
        type_q[g] <= ld_type_i[g];
        icnt_q[g] <= ld_icnt_i[g];
        hist_q[g] <= ld_hist_i[g];
      end else if (pop && (sel == SEL_W'(g))) begin
        v_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trace_block_tracker.sv
module trace_block_tracker
  import trace_blk_pkg::*;
#(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hist_mode_i,
  input  logic              ret_valid_i,
  output logic              ret_ready_o,
  input  logic              ret_size_i,
  input  logic [1:0]        ret_kind_i,
  input  logic              ret_taken_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [1:0]        msg_type_o,
  output logic [ICNT_W-1:0] msg_icnt_o,
  output logic [HIST_W-1:0] msg_hist_o,
  output logic [ICNT_W-1:0] icnt_o,
  output logic [HIST_W-1:0] hist_o
);
  logic [ICNT_W-1:0] cnt_q, cnt_d, blk_cnt;
  logic [HIST_W-1:0] hist_q, hist_d, shifted;
  logic              ovf, hfull, ends, shift, accept, busy;
  logic              is_cond, is_ind;

  logic [NSLOT-1:0]             ld_v;
  logic [NSLOT-1:0][1:0]        ld_type;
  logic [NSLOT-1:0][ICNT_W-1:0] ld_icnt;
  logic [NSLOT-1:0][HIST_W-1:0] ld_hist;

  assign is_cond = (ret_kind_i == RK_DCOND);
  assign is_ind  = (ret_kind_i == RK_INDIR);
  assign ends    = is_ind | (is_cond & ~hist_mode_i & ret_taken_i);
  assign shift   = is_cond & hist_mode_i;
  assign accept  = ret_valid_i & ret_ready_o;

  tbt_icnt_unit #(.ICNT_W(ICNT_W)) u_icnt (
    .cnt_q_i   (cnt_q),
    .size_i    (ret_size_i),
    .ends_i    (ends),
    .cnt_d_o   (cnt_d),
    .ovf_o     (ovf),
    .blk_cnt_o (blk_cnt)
  );

  tbt_hist_unit #(.HIST_W(HIST_W)) u_hist (
    .hist_q_i  (hist_q),
    .shift_i   (shift),
    .taken_i   (ret_taken_i),
    .clear_i   (ends),
    .hist_d_o  (hist_d),
    .shifted_o (shifted),
    .full_o    (hfull)
  );

  always_comb begin
    ld_v[SLOT_CNT]    = ovf;
    ld_type[SLOT_CNT] = MSG_FULL_CNT;
    ld_icnt[SLOT_CNT] = cnt_q;
    ld_hist[SLOT_CNT] = '0;

    ld_v[SLOT_HIST]    = hfull;
    ld_type[SLOT_HIST] = MSG_FULL_HIST;
    ld_icnt[SLOT_HIST] = '0;
    ld_hist[SLOT_HIST] = shifted;

    ld_v[SLOT_BR]    = ends;
    ld_type[SLOT_BR] = is_ind ? MSG_IND : MSG_DIR;
    ld_icnt[SLOT_BR] = blk_cnt;
    ld_hist[SLOT_BR] = hist_q;
  end

  tbt_msg_slots #(.ICNT_W(ICNT_W), .HIST_W(HIST_W)) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .ld_v_i      (ld_v),
    .ld_type_i   (ld_type),
    .ld_icnt_i   (ld_icnt),
    .ld_hist_i   (ld_hist),
    .msg_ready_i (msg_ready_i),
    .msg_valid_o (msg_valid_o),
    .msg_type_o  (msg_type_o),
    .msg_icnt_o  (msg_icnt_o),
    .msg_hist_o  (msg_hist_o),
    .busy_o      (busy)
  );

  assign ret_ready_o = ~busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hist_q <= HIST_W'(1);
    end else if (accept) begin
      cnt_q  <= cnt_d;
      hist_q <= hist_d;
    end
  end

  assign icnt_o = cnt_q;
  assign hist_o = hist_q;
endmodule

// File: rtl/trace_block_tracker_chk.sv
module trace_block_tracker_chk #(
  parameter int ICNT_W = 8,
  parameter int HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hist_mode_i,
  input logic              ret_valid_i,
  input logic              ret_ready_o,
  input logic              ret_size_i,
  input logic [1:0]        ret_kind_i,
  input logic              ret_taken_i,
  input logic              msg_valid_o,
  input logic              msg_ready_i,
  input logic [1:0]        msg_type_o,
  input logic [ICNT_W-1:0] msg_icnt_o,
  input logic [HIST_W-1:0] msg_hist_o,
  input logic [ICNT_W-1:0] icnt_o,
  input logic [HIST_W-1:0] hist_o
);
  localparam logic [ICNT_W:0] CMAX = {1'b0, {ICNT_W{1'b1}}};

  logic            acc;
  logic [ICNT_W:0] step, nxt;
  assign acc  = ret_valid_i & ret_ready_o;
  assign step = ret_size_i ? (ICNT_W+1)'(2) : (ICNT_W+1)'(1);
  assign nxt  = {1'b0, icnt_o} + step;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_type_o)
      && $stable(msg_icnt_o) && $stable(msg_hist_o));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_ready_o |=> $stable(icnt_o) && $stable(hist_o));

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !ret_ready_o);

  assert_marker_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_o != '0 && !hist_o[HIST_W-1]);

  assert_full_hist_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_type_o == 2'd3 |-> msg_hist_o[HIST_W-1] && msg_icnt_o == '0);

  assert_seq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ret_kind_i == 2'd0 && nxt <= CMAX |=>
      {1'b0, icnt_o} == $past(nxt) && !msg_valid_o);

  assert_ind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ret_kind_i == 2'd3 |=> msg_valid_o && icnt_o == '0 && hist_o == HIST_W'(1));

  assert_branch_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !hist_mode_i && ret_kind_i != 2'd3 && !(ret_kind_i == 2'd1 && ret_taken_i)
      |=> $stable(hist_o));
endmodule

bind trace_block_tracker trace_block_tracker_chk #(.ICNT_W(ICNT_W), .HIST_W(HIST_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hist_mode_i (hist_mode_i),
  .ret_valid_i (ret_valid_i),
  .ret_ready_o (ret_ready_o),
  .ret_size_i  (ret_size_i),
  .ret_kind_i  (ret_kind_i),
  .ret_taken_i (ret_taken_i),
  .msg_valid_o (msg_valid_o),
  .msg_ready_i (msg_ready_i),
  .msg_type_o  (msg_type_o),
  .msg_icnt_o  (msg_icnt_o),
  .msg_hist_o  (msg_hist_o),
  .icnt_o      (icnt_o),
  .hist_o      (hist_o)
);

// File: tb/trace_block_tracker_test.sv
module trace_block_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4;
  localparam int HW = 4;
  localparam int CMAX = (1 << IW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hist_mode_i = 1'b0, ret_valid_i = 1'b0, ret_size_i = 1'b0, ret_taken_i = 1'b0;
  logic [1:0] ret_kind_i = 2'd0;
  logic msg_ready_i = 1'b0;
  logic ret_ready_o, msg_valid_o;
  logic [1:0] msg_type_o;
  logic [IW-1:0] msg_icnt_o, icnt_o;
  logic [HW-1:0] msg_hist_o, hist_o;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_hist = 1;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_block_tracker #(.ICNT_W(IW), .HIST_W(HW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .hist_mode_i(hist_mode_i),
    .ret_valid_i(ret_valid_i), .ret_ready_o(ret_ready_o), .ret_size_i(ret_size_i),
    .ret_kind_i(ret_kind_i), .ret_taken_i(ret_taken_i), .msg_valid_o(msg_valid_o),
    .msg_ready_i(msg_ready_i), .msg_type_o(msg_type_o), .msg_icnt_o(msg_icnt_o),
    .msg_hist_o(msg_hist_o), .icnt_o(icnt_o), .hist_o(hist_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int t);
    case (t)
      0: return "R5";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic retire(input int sz, input int kd, input int tk, input int md, input bit hold);
    int e_t[3], e_c[3], e_h[3];
    int ne = 0, s, base, nh;
    bit ovf, ends;
    string st;
    s = sz ? 2 : 1;
    ovf = (m_cnt + s) > CMAX;
    ends = (kd == 3) || (kd == 1 && md == 0 && tk != 0);
    base = ovf ? 0 : m_cnt;
    if (ovf) begin e_t[ne] = 2; e_c[ne] = m_cnt; e_h[ne] = 0; ne++; end
    if (ends) begin
      e_t[ne] = (kd == 3) ? 0 : 1; e_c[ne] = base + s; e_h[ne] = m_hist; ne++;
      m_cnt = 0; m_hist = 1;
    end else begin
      m_cnt = base + s;
      if (kd == 1 && md != 0) begin
        nh = ((m_hist << 1) | tk) & ((1 << HW) - 1);
        if (nh >= (1 << (HW - 1))) begin
          e_t[ne] = 3; e_c[ne] = 0; e_h[ne] = nh; ne++; m_hist = 1;
        end else m_hist = nh;
      end
    end
    if (kd == 3) st = "R5";
    else if (kd == 1 && md == 0 && tk != 0) st = "R4";
    else if (kd == 1 && md != 0) st = "R3";
    else st = "R2";

    @(negedge clk);
    chk("R9", "ret_ready idle", int'(ret_ready_o), 1);
    hist_mode_i = md[0]; ret_size_i = sz[0]; ret_kind_i = kd[1:0]; ret_taken_i = tk[0];
    ret_valid_i = 1'b1;
    @(negedge clk);
    ret_valid_i = 1'b0;
    for (int k = 0; k < ne; k++) begin
      if (hold && k == 0) begin
        ret_valid_i = 1'b1; ret_kind_i = 2'd3; ret_size_i = 1'b1; msg_ready_i = 1'b0;
        @(negedge clk);
        ret_valid_i = 1'b0;
        chk("R9", "held type", int'(msg_type_o), e_t[0]);
        chk("R9", "held icnt", int'(msg_icnt_o), e_c[0]);
        chk("R9", "ready low while pending", int'(ret_ready_o), 0);
        chk("R9", "icnt frozen", int'(icnt_o), m_cnt);
        chk("R9", "hist frozen", int'(hist_o), m_hist);
      end
      chk(ne > 1 ? "R8" : tag_of(e_t[k]), "msg_valid", int'(msg_valid_o), 1);
      chk(ne > 1 ? "R8" : tag_of(e_t[k]), "msg_type", int'(msg_type_o), e_t[k]);
      chk(tag_of(e_t[k]), "msg_icnt", int'(msg_icnt_o), e_c[k]);
      chk(tag_of(e_t[k]), "msg_hist", int'(msg_hist_o), e_h[k]);
      msg_ready_i = 1'b1;
      @(negedge clk);
      msg_ready_i = 1'b0;
    end
    chk(ne > 0 ? "R8" : st, "no further msg", int'(msg_valid_o), 0);
    chk(ovf ? "R6" : st, "icnt", int'(icnt_o), m_cnt);
    chk(md == 0 ? "R10" : st, "hist", int'(hist_o), m_hist);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lcg = 7;
    repeat (3) @(negedge clk);
    chk("R1", "icnt reset", int'(icnt_o), 0);
    chk("R1", "hist reset", int'(hist_o), 1);
    chk("R1", "msg_valid reset", int'(msg_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "ret_ready reset", int'(ret_ready_o), 1);

    // directed: count and history fill on the same instruction (R8)
    for (int i = 0; i < 6; i++) retire(1, 0, 0, 1, 0);
    retire(0, 1, 1, 1, 0);
    retire(0, 1, 0, 1, 0);
    retire(1, 1, 1, 1, 1);

    // sweep: every mode, kind, size, outcome from every starting count
    for (int md = 0; md < 2; md++)
      for (int kd = 0; kd < 4; kd++)
        for (int sz = 0; sz < 2; sz++)
          for (int tk = 0; tk < 2; tk++)
            for (int c = 0; c <= CMAX; c++) begin
              retire(0, 3, 0, md, 0);
              retire(0, 3, 0, md, 0);
              while (m_cnt + 2 <= c) retire(1, 0, 0, md, 0);
              if (m_cnt < c) retire(0, 2, 0, md, 0);
              retire(sz, kd, tk, md, (c % 5) == 0);
            end

    // long mixed streams for history patterns
    for (int it = 0; it < 3000; it++) begin
      lcg = lcg * 1103515245 + 12345;
      retire((lcg >> 16) & 1, (lcg >> 17) & 3, (lcg >> 19) & 1, (it / 300) % 2,
             ((lcg >> 21) & 15) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule